// File: doc/BRIEF.md
# Manchester Bit Recovery with Edge Blanking

This block takes a single-ended 10 Mbit/s Manchester line, sampled by a fast local clock, and turns it into a stream of decoded bits with a one-cycle valid strobe. The line is first resynchronised to the sampling clock. Every level change is then found by comparing the synchronised level with its value one cycle earlier.

A fixed-length, non-retriggerable blanking window removes the transitions that fall on cell boundaries. The first transition seen while the window is closed is accepted and opens the window. Any transition that arrives while the window is open is discarded and does not lengthen it. The level just after an accepted transition is the decoded bit. A carrier-sense output stays high while accepted transitions keep arriving and drops after a programmable quiet time.

With the default 80 MHz sampling clock, one bit cell is 8 cycles, the window is 6 cycles (75 ns) and the carrier hold is 16 cycles (200 ns). No phase tracking is done: the fixed window alone locks onto the mid-cell transitions.

Top module: `manch_rx`

## Requirements
- R1: While rst_ni is low and at the first sample after its release, bit_valid_o, bit_data_o and carrier_o are all 0.
- R2: When line_i changes and no window is open, bit_valid_o is high for exactly one cycle, starting 3 clock edges after the first edge that samples the new level (SYNC_STAGES + 1 registers).
- R3: Two bit_valid_o strobes are never closer than BLANK_CYC cycles.
- R4: A transition arriving 1 to BLANK_CYC-1 cycles after an accepted one is ignored, and a transition arriving BLANK_CYC or more cycles after it is accepted.
- R5: The window is not retriggerable. Given transitions at 0, BLANK_CYC/2 and BLANK_CYC cycles, the first and the third are accepted.
- R6: bit_data_o equals the line level after the accepted transition and holds until the next strobe.
- R7: For a Manchester stream where a 1 is low-then-high within the cell and a 0 is high-then-low (half cell 4 cycles), sent LSB first, one strobe comes per bit, 8 cycles apart, and the bits match in order. Boundary transitions between equal bits produce no strobe.
- R8: carrier_o rises in the same cycle as the first bit_valid_o. It stays high while strobes are at most HOLD_CYC cycles apart. It is high for exactly HOLD_CYC cycles, counted from the last strobe, and then falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| line_i | input | 1 | Asynchronous Manchester line level |
| bit_valid_o | output | 1 | One-cycle strobe per accepted transition |
| bit_data_o | output | 1 | Decoded bit, held between strobes |
| carrier_o | output | 1 | Carrier sense |

## Verification
The bench builds the block with its defaults: SYNC_STAGES=2, BLANK_CYC=6 and HOLD_CYC=16, with an 8-cycle bit cell. At this size, every one of the 256 byte values can be sent as its own burst. Every transition spacing from 1 to 9 cycles around the window edge is tried. The exact carrier hold length is counted in cycles.

// File: rtl/manch_rx_pkg.sv
package manch_rx_pkg;
  typedef struct packed {
    logic valid;
    logic data;
  } rx_bit_t;
endpackage

// File: rtl/manch_rx_sync.sv
module manch_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stage_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[i] <= 1'b0;
        else if (i == 0) stage_q[i] <= d_i;
        else stage_q[i] <= stage_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/manch_rx_edge.sv
module manch_rx_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  output logic edge_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else prev_q <= level_i;
  end

  assign edge_o = level_i ^ prev_q;
endmodule

// File: rtl/manch_rx_blank.sv
module manch_rx_blank
  import manch_rx_pkg::*;
#(
  parameter int unsigned BLANK_CYC = 6
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    edge_i,
  input  logic    level_i,
  output logic    accept_o,
  output rx_bit_t bit_o
);
  localparam int unsigned CW = (BLANK_CYC > 2) ? $clog2(BLANK_CYC) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(BLANK_CYC - 1);

  logic [CW-1:0] cnt_q;
  rx_bit_t       bit_q;
  logic          open_w;

  assign open_w   = (cnt_q == '0);
  assign accept_o = edge_i && open_w;

  // window starts on accept only; edges inside it never reload
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (accept_o) cnt_q <= RELOAD;
    else if (!open_w) cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q <= '0;
    end else begin
      bit_q.valid <= accept_o;
      if (accept_o) bit_q.data <= level_i;
    end
  end

  assign bit_o = bit_q;

  // R2
  accept_when_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_i && cnt_q == '0) |=> bit_o.valid);
  // R4
  blank_ignores_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |=> !bit_o.valid);
  // R6
  data_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_o.valid |-> bit_o.data == $past(level_i));
endmodule

// File: rtl/manch_rx_carrier.sv
module manch_rx_carrier #(
  parameter int unsigned HOLD_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic accept_i,
  output logic carrier_o
);
  localparam int unsigned HW = $clog2(HOLD_CYC + 1);
  localparam logic [HW-1:0] LAST = HW'(HOLD_CYC - 1);

  logic [HW-1:0] idle_q;
  logic          carrier_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_q    <= '0;
      carrier_q <= 1'b0;
    end else if (accept_i) begin
      idle_q    <= '0;
      carrier_q <= 1'b1;
    end else if (carrier_q) begin
      if (idle_q == LAST) carrier_q <= 1'b0;
      else idle_q <= idle_q + 1'b1;
    end
  end

  assign carrier_o = carrier_q;

  // R8
  carrier_stays_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!carrier_q && !accept_i) |=> !carrier_q);
  // R8
  carrier_rises_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |=> carrier_q);
endmodule

// File: rtl/manch_rx.sv
module manch_rx
  import manch_rx_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned BLANK_CYC   = 6,
  parameter int unsigned HOLD_CYC    = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic bit_valid_o,
  output logic bit_data_o,
  output logic carrier_o
);
  logic    level_w;
  logic    edge_w;
  logic    accept_w;
  rx_bit_t bit_w;

  manch_rx_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (line_i),
    .q_o   (level_w)
  );

  manch_rx_edge edge_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .level_i(level_w),
    .edge_o (edge_w)
  );

  manch_rx_blank #(.BLANK_CYC(BLANK_CYC)) blank_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .edge_i  (edge_w),
    .level_i (level_w),
    .accept_o(accept_w),
    .bit_o   (bit_w)
  );

  manch_rx_carrier #(.HOLD_CYC(HOLD_CYC)) carrier_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept_w),
    .carrier_o(carrier_o)
  );

  assign bit_valid_o = bit_w.valid;
  assign bit_data_o  = bit_w.data;

  // R3
  strobe_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_valid_o |=> !bit_valid_o);
  // R8
  strobe_has_carrier_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_valid_o |-> carrier_o);
endmodule

// File: tb/manch_rx_tb_top.sv
module manch_rx_tb_top;
  localparam int BLANK = 6;
  localparam int HOLD  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line = 1'b0;
  logic bit_valid, bit_data, carrier;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int n_strobe, t_first, t_last;
  logic last_data;
  logic [7:0] rx_byte;
  bit done = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  manch_rx #(.SYNC_STAGES(2), .BLANK_CYC(BLANK), .HOLD_CYC(HOLD)) dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .line_i     (line),
    .bit_valid_o(bit_valid),
    .bit_data_o (bit_data),
    .carrier_o  (carrier)
  );

  always @(negedge clk) begin
    if (bit_valid) begin
      if (n_strobe == 0) t_first = cyc;
      t_last = cyc;
      last_data = bit_data;
      if (n_strobe < 8) rx_byte[n_strobe] = bit_data;
      n_strobe++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear();
    @(posedge clk);
    n_strobe = 0; t_first = 0; t_last = 0; rx_byte = '0; last_data = 1'b0;
  endtask

  task automatic quiet();
    repeat (HOLD + 8) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(bit_valid == 1'b0, "R1 valid", bit_valid, 0);
    chk(bit_data == 1'b0, "R1 data", bit_data, 0);
    chk(carrier == 1'b0, "R1 carrier", carrier, 0);

    // R2 latency, R8 carrier hold length
    line = 1'b1;
    repeat (2) @(negedge clk);
    chk(bit_valid == 1'b0, "R2 early", bit_valid, 0);
    @(negedge clk);
    chk(bit_valid == 1'b1, "R2 strobe", bit_valid, 1);
    chk(carrier == 1'b1, "R8 rise", carrier, 1);
    begin
      int hi = 0;
      for (int k = 0; k < 40; k++) begin
        if (carrier) hi++;
        @(negedge clk);
      end
      chk(hi == HOLD, "R8 hold", hi, HOLD);
    end
    chk(bit_valid == 1'b0, "R2 single", bit_valid, 0);

    // R3 R4 R6 spacing sweep
    for (int d = 1; d <= BLANK + 3; d++) begin
      quiet();
      clear();
      @(negedge clk); line = ~line;
      repeat (d) @(negedge clk);
      line = ~line;
      repeat (20) @(negedge clk);
      chk(n_strobe == ((d >= BLANK) ? 2 : 1), "R4 count", n_strobe, (d >= BLANK) ? 2 : 1);
      if (d >= BLANK) begin
        chk(t_last - t_first == d, "R3 gap", t_last - t_first, d);
        chk(last_data == line, "R6 data", last_data, line);
      end else begin
        chk(last_data == ~line, "R6 data", last_data, ~line);
      end
    end

    // R5 non-retriggerable
    quiet();
    clear();
    @(negedge clk); line = ~line;
    repeat (BLANK / 2) @(negedge clk); line = ~line;
    repeat (BLANK - BLANK / 2) @(negedge clk); line = ~line;
    repeat (20) @(negedge clk);
    chk(n_strobe == 2, "R5 count", n_strobe, 2);
    chk(t_last - t_first == BLANK, "R5 gap", t_last - t_first, BLANK);
    chk(last_data == line, "R5 data", last_data, line);

    // R7 all byte values
    for (int v = 0; v < 256; v++) begin
      logic [7:0] b;
      b = v[7:0];
      @(negedge clk); line = ~b[0];
      quiet();
      clear();
      @(negedge clk);
      for (int i = 0; i < 8; i++) begin
        line = ~b[i];
        repeat (4) @(negedge clk);
        line = b[i];
        repeat (4) @(negedge clk);
      end
      repeat (6) @(negedge clk);
      chk(n_strobe == 8, "R7 count", n_strobe, 8);
      chk(rx_byte == b, "R7 bits", rx_byte, b);
      chk(t_last - t_first == 56, "R7 spacing", t_last - t_first, 56);
      chk(carrier == 1'b1, "R8 sustain", carrier, 1);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule